// File: doc/BRIEF.md
# Cache Port Flow Controller

This block is the flow-control front of one port of a cache. On the inbound side it decides, in the same cycle, whether an arriving transfer is taken or turned away. Requests are turned away while the port is marked blocked, and the block remembers that it turned one away. When the blocked mark is lifted it gives the upstream agent a single retry pulse, but only if something was turned away. On the port that faces the processor, a cacheable invalidate or upgrade that neither reads nor writes is taken at once, even while blocked, and gets no response.

On the outbound side the block drives a send/accept link that may refuse any transfer. It carries two kinds of traffic: responses produced by the cache, and requests raised by a request source. On the memory-facing port these are miss requests; on the processor-facing port they are coherence requests. A refused response goes into a small first-in first-out drain queue. After any refusal the port goes quiet until the downstream side sends a retry strobe. Queued responses always go out ahead of new responses and ahead of requests, so response order is kept.

Top module: `cache_port_flow`

## Requirements
- R1: While blocked, an inbound transfer with `in_is_req`=1 that is not absorbed sees `in_accept`=0. A transfer with `in_is_req`=0, or any transfer while not blocked, sees `in_accept`=1 in the same cycle.
- R2: `block_set` marks the port blocked and forgets any earlier rejection. `block_clr` on a blocked port unblocks it. In the next cycle `up_retry` is high for exactly one cycle, and only if a request was rejected since the last `block_set`, including in the `block_clr` cycle itself.
- R3: With `CPU_SIDE`=1, a transfer with `in_is_req`=1, `in_cacheable`=1, `in_inval`=1, `in_read`=0 and `in_write`=0 gives `in_accept`=1 and `in_absorbed`=1, whether or not the port is blocked. It does not count as a rejection. Every other transfer gives `in_absorbed`=0.
- R4: A response arriving while the port is not stalled and the queue is empty is presented on the output in the same cycle. Otherwise it is appended to the queue. Responses leave in arrival order.
- R5: A presented transfer with `out_accept`=0 sets `stalled`=1 from the next cycle. A refused direct response is appended to the queue.
- R6: While `stalled`=1 and `down_retry`=0, `out_valid`=0.
- R7: When the queue is non-empty, each send attempt presents the queue head (`out_is_rsp`=1), ahead of a new response and ahead of a pending request. The head leaves the queue only when `out_accept`=1.
- R8: A send attempt is made every cycle that the port is not stalled. After an accepted send, the remaining work is presented in the very next cycle.
- R9: A `down_retry` that finds the queue empty and `req_pending`=0 presents nothing and clears `stalled` for the next cycle.
- R10: `out_nack` is 1 for a response that entered with `rsp_nack`=1 and 0 for every other response and for every request.
- R11: `q_full`=1 when `DEPTH` responses are queued. A response arriving while `q_full`=1 gives `q_err`=1 in that cycle and is dropped.
- R12: In a cycle where a request is presented (`out_valid`=1, `out_is_rsp`=0), `req_taken` equals `out_accept` and `req_refused` is its inverse. Both are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound transfer present |
| in_is_req | input | 1 | Inbound transfer is a request |
| in_cacheable | input | 1 | Inbound transfer is cacheable |
| in_inval | input | 1 | Inbound transfer invalidates |
| in_read | input | 1 | Inbound transfer reads |
| in_write | input | 1 | Inbound transfer writes |
| in_accept | output | 1 | Inbound transfer taken this cycle |
| in_absorbed | output | 1 | Inbound transfer taken and satisfied with no response |
| block_set | input | 1 | Mark the port blocked |
| block_clr | input | 1 | Lift the blocked mark |
| up_retry | output | 1 | One-cycle retry pulse to the upstream agent |
| rsp_valid | input | 1 | New response from the cache |
| rsp_data | input | DATA_W | Response payload |
| rsp_nack | input | 1 | Response is negatively acknowledged |
| req_pending | input | 1 | Request source has a request to send |
| req_data | input | DATA_W | Request payload |
| req_taken | output | 1 | Request accepted downstream this cycle |
| req_refused | output | 1 | Request refused downstream this cycle |
| out_valid | output | 1 | Outbound transfer presented |
| out_data | output | DATA_W | Outbound payload |
| out_is_rsp | output | 1 | Outbound transfer is a response |
| out_nack | output | 1 | Result code: 1 NACK, 0 success |
| out_accept | input | 1 | Downstream takes the presented transfer |
| down_retry | input | 1 | Retry strobe from downstream |
| stalled | output | 1 | Port waits for a retry strobe |
| q_full | output | 1 | Drain queue full |
| q_err | output | 1 | Response arrived while queue full |

## Verification
The hardest state to reach from the ports is a full drain queue that still holds responses in order behind a refused head. The bench gets there by refusing one direct response, which stalls the port. It then feeds further responses while no retry strobe arrives, so all of them queue. It overflows the queue by one, refuses a retry to show the head stays in place, and then drains with accepted retries, checking each payload against its arrival index.

// File: rtl/cache_port_flow.sv
module cache_port_flow #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter bit CPU_SIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_is_req,
  input  logic              in_cacheable,
  input  logic              in_inval,
  input  logic              in_read,
  input  logic              in_write,
  output logic              in_accept,
  output logic              in_absorbed,
  input  logic              block_set,
  input  logic              block_clr,
  output logic              up_retry,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_nack,
  input  logic              req_pending,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_taken,
  output logic              req_refused,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_rsp,
  output logic              out_nack,
  input  logic              out_accept,
  input  logic              down_retry,
  output logic              stalled,
  output logic              q_full,
  output logic              q_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          blocked, must_retry;
  logic          reject;
  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          q_empty, attempt, head_try, byp_try, req_try, push, pop;

  assign in_absorbed = CPU_SIDE && in_valid && in_is_req && in_cacheable
                       && in_inval && !in_read && !in_write;
  assign reject      = in_valid && in_is_req && blocked && !in_absorbed;
  assign in_accept   = in_valid && !reject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked    <= 1'b0;
      must_retry <= 1'b0;
      up_retry   <= 1'b0;
    end else begin
      up_retry <= 1'b0;
      if (block_set) begin
        blocked    <= 1'b1;
        must_retry <= 1'b0;
      end else if (block_clr && blocked) begin
        blocked    <= 1'b0;
        up_retry   <= must_retry || reject;
        must_retry <= 1'b0;
      end else if (reject) begin
        must_retry <= 1'b1;
      end
    end
  end

  assign q_empty  = (cnt == '0);
  assign q_full   = (cnt == CW'(DEPTH));
  assign q_err    = rsp_valid && q_full;

  assign attempt  = !stalled || down_retry;
  assign head_try = attempt && !q_empty;
  assign byp_try  = attempt && !stalled && q_empty && rsp_valid;
  assign req_try  = attempt && !head_try && !byp_try && req_pending;

  assign out_valid  = head_try || byp_try || req_try;
  assign out_is_rsp = head_try || byp_try;
  assign out_data   = head_try ? mem[rd_ptr][DATA_W-1:0] :
                      byp_try  ? rsp_data : req_data;
  assign out_nack   = head_try ? mem[rd_ptr][DATA_W] :
                      byp_try  ? rsp_nack : 1'b0;

  assign req_taken   = req_try && out_accept;
  assign req_refused = req_try && !out_accept;

  assign pop  = head_try && out_accept;
  assign push = rsp_valid && !q_full && !(byp_try && out_accept);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      stalled <= 1'b0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= {rsp_nack, rsp_data};
        wr_ptr      <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (out_valid)
        stalled <= !out_accept;
      else if (down_retry)
        stalled <= 1'b0;
    end
  end
endmodule

// File: rtl/cache_port_flow_chk.sv
module cache_port_flow_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_is_req,
  input logic in_absorbed,
  input logic in_accept,
  input logic blocked,
  input logic block_clr,
  input logic up_retry,
  input logic out_valid,
  input logic out_is_rsp,
  input logic out_accept,
  input logic down_retry,
  input logic stalled,
  input logic q_empty,
  input logic q_full,
  input logic q_err
);
  a_r1_reject_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_req && blocked && !in_absorbed) |-> !in_accept);
  a_r2_retry_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    up_retry |-> $past(block_clr));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_retry |=> !up_retry);
  a_r3_absorb_taken: assert property (@(posedge clk) disable iff (!rst_n)
    in_absorbed |-> in_accept);
  a_r5_refuse_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_accept) |=> stalled);
  a_r6_quiet_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !down_retry) |-> !out_valid);
  a_r7_head_first: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !q_empty) |-> out_is_rsp);
  a_r11_err_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    q_err |-> q_full);
endmodule

bind cache_port_flow cache_port_flow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_req(in_is_req),
  .in_absorbed(in_absorbed), .in_accept(in_accept), .blocked(blocked),
  .block_clr(block_clr), .up_retry(up_retry), .out_valid(out_valid),
  .out_is_rsp(out_is_rsp), .out_accept(out_accept), .down_retry(down_retry),
  .stalled(stalled), .q_empty(q_empty), .q_full(q_full), .q_err(q_err)
);

// File: tb/cache_port_flow_bench.sv
module cache_port_flow_bench;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_is_req, in_cacheable, in_inval, in_read, in_write;
  logic in_accept, in_absorbed, block_set, block_clr, up_retry;
  logic rsp_valid, rsp_nack, req_pending;
  logic [DW-1:0] rsp_data, req_data, out_data;
  logic req_taken, req_refused, out_valid, out_is_rsp, out_nack;
  logic out_accept, down_retry, stalled, q_full, q_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cache_port_flow #(.DATA_W(DW), .DEPTH(DEPTH), .CPU_SIDE(1'b1)) u_cache_port_flow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_req(in_is_req),
    .in_cacheable(in_cacheable), .in_inval(in_inval), .in_read(in_read),
    .in_write(in_write), .in_accept(in_accept), .in_absorbed(in_absorbed),
    .block_set(block_set), .block_clr(block_clr), .up_retry(up_retry),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
    .req_pending(req_pending), .req_data(req_data), .req_taken(req_taken),
    .req_refused(req_refused), .out_valid(out_valid), .out_data(out_data),
    .out_is_rsp(out_is_rsp), .out_nack(out_nack), .out_accept(out_accept),
    .down_retry(down_retry), .stalled(stalled), .q_full(q_full), .q_err(q_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; block_set = 0; block_clr = 0; rsp_valid = 0;
    rsp_nack = 0; down_retry = 0; out_accept = 1;
    #1;
  endtask

  task automatic drive_in(input logic [4:0] v);
    in_valid = 1;
    {in_is_req, in_cacheable, in_inval, in_read, in_write} = v;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_is_req = 0; in_cacheable = 0; in_inval = 0;
    in_read = 0; in_write = 0; block_set = 0; block_clr = 0; rsp_valid = 0;
    rsp_data = 0; rsp_nack = 0; req_pending = 0; req_data = 0;
    out_accept = 1; down_retry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("reset R6 out_valid", out_valid, 0);
    chk("reset R6 stalled", stalled, 0);
    chk("reset R2 up_retry", up_retry, 0);
    chk("reset R11 q_full", q_full, 0);

    // R1 R3: sweep of all inbound attribute combinations, blocked
    block_set = 1; step();
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      int absorb;
      b = 5'(v);
      drive_in(b);
      absorb = (b == 5'b11100) ? 1 : 0;
      chk("R3 absorbed blocked", in_absorbed, absorb);
      chk("R1 accept blocked", in_accept, (b[4] && !absorb) ? 0 : 1);
      step();
    end
    block_clr = 1; step();
    chk("R2 retry pulse", up_retry, 1);
    step();
    chk("R2 single pulse", up_retry, 0);

    // R1 R3: same sweep, unblocked
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      b = 5'(v);
      drive_in(b);
      chk("R1 accept unblocked", in_accept, 1);
      chk("R3 absorbed unblocked", in_absorbed, (b == 5'b11100) ? 1 : 0);
      step();
    end

    // R2: a second block_set forgets the rejection
    block_set = 1; step();
    drive_in(5'b10010); step();
    block_set = 1; step();
    block_clr = 1; step();
    chk("R2 set forgets reject", up_retry, 0);
    // R3: only absorbed traffic while blocked gives no retry
    block_set = 1; step();
    drive_in(5'b11100); step();
    block_clr = 1; step();
    chk("R3 absorb no retry", up_retry, 0);
    // R2: rejection in the clear cycle still counts
    block_set = 1; step();
    block_clr = 1; drive_in(5'b10001); step();
    chk("R2 reject in clr cycle", up_retry, 1);
    step();

    // R4 R10: direct responses
    rsp_valid = 1; rsp_data = 8'h11; rsp_nack = 0; #1;
    chk("R4 bypass valid", out_valid, 1);
    chk("R4 bypass data", out_data, 8'h11);
    chk("R10 success code", out_nack, 0);
    step();
    rsp_valid = 1; rsp_data = 8'h22; rsp_nack = 1; #1;
    chk("R10 nack code", out_nack, 1);
    step();

    // R5: refused direct response
    rsp_valid = 1; rsp_data = 8'h33; out_accept = 0; #1;
    chk("R5 presented", out_valid, 1);
    step();
    chk("R5 stalled", stalled, 1);
    rsp_valid = 1; rsp_data = 8'h44; #1;
    chk("R6 quiet with rsp", out_valid, 0);
    step();
    req_pending = 1; req_data = 8'h99; #1;
    chk("R6 quiet with req", out_valid, 0);
    chk("R12 no take while stalled", req_taken, 0);
    step();
    // R7: retry sends queue head before request
    down_retry = 1; #1;
    chk("R7 head is rsp", out_is_rsp, 1);
    chk("R7 head data", out_data, 8'h33);
    step();
    chk("R8 stall cleared", stalled, 0);
    rsp_valid = 1; rsp_data = 8'h55; #1;
    chk("R8 next cycle send", out_valid, 1);
    chk("R4 order second", out_data, 8'h44);
    step();
    chk("R4 order third", out_data, 8'h55);
    step();
    chk("R12 req presented", out_is_rsp, 0);
    chk("R12 req data", out_data, 8'h99);
    chk("R12 req taken", req_taken, 1);
    chk("R10 req code", out_nack, 0);
    step();
    out_accept = 0; #1;
    chk("R12 req refused", req_refused, 1);
    chk("R12 no take", req_taken, 0);
    step();
    chk("R5 stalled after req", stalled, 1);
    req_pending = 0;
    down_retry = 1; #1;
    chk("R9 nothing sent", out_valid, 0);
    step();
    chk("R9 stall cleared", stalled, 0);

    // R11: fill the queue behind a refused response
    rsp_valid = 1; rsp_data = 8'hA0; out_accept = 0; step();
    for (int i = 1; i < DEPTH; i++) begin
      rsp_valid = 1; rsp_data = 8'(8'hA0 + i); rsp_nack = i[0];
      step();
    end
    chk("R11 full", q_full, 1);
    rsp_valid = 1; rsp_data = 8'hEE; #1;
    chk("R11 err", q_err, 1);
    step();
    down_retry = 1; out_accept = 0; #1;
    chk("R7 refused head", out_data, 8'hA0);
    step();
    chk("R7 head kept stalled", stalled, 1);
    down_retry = 1; #1;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R7 drain data", out_data, 8'hA0 + i);
      chk("R10 drain code", out_nack, i % 2);
      step();
    end
    chk("R11 overflow dropped", out_valid, 0);
    chk("R11 empty again", q_full, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule